// File: doc/BRIEF.md
# CPU Status Flag Register

This block holds the status byte of a small 8-bit processor core. Three arithmetic flags sit in it: zero, digit carry (the carry out of bit 3) and carry (the carry out of bit 7). For subtraction the ALU adds the two's complement of the second operand, so its carry and digit-carry results arrive as inverted borrows, and this register stores them unchanged. Two power-status flags sit beside them. One records a watchdog time-out and the other records entry into sleep.

The core writes the register through a software write port whenever an instruction names it as its destination. In the same cycle the ALU may present new flag values with a per-flag update enable. If the instruction affects any arithmetic flag, the ALU results win and the written data for the three arithmetic bits is dropped. Flags that the ALU does not update keep their old value. Instructions that affect no flag, such as bit set, bit clear, swap and move, write the arithmetic bits directly. The two power-status bits ignore software. Only the watchdog-clear, sleep and time-out events change them, and reset returns them to the power-up state.

Top module: `cpu_status_reg`

## Requirements
- R1: Bits 7, 6 and 5 of `stat_o` always read as 0.
- R2: The layout is fixed: bit 4 is the time-out flag, bit 3 is the power-down flag, bit 2 is Z, bit 1 is DC and bit 0 is C. `alu_upd` and `alu_flags` use the same order, with bit 2 for Z, bit 1 for DC and bit 0 for C.
- R3: When `sw_we` is high and no bit of `alu_upd` is set, bits 2:0 of `sw_wdata` load into Z, DC and C on the next clock edge.
- R4: When any bit of `alu_upd` is set, all of `sw_wdata[2:0]` is discarded. Each enabled flag takes its `alu_flags` value, and each flag that is not enabled keeps its value, even when `sw_we` is high.
- R5: `sw_wdata[4:3]` never changes the time-out or power-down bits.
- R6: The time-out flag clears on `evt_wdt_to`. This event takes priority over every other event. Without it, `evt_clrwdt` or `evt_sleep` sets the flag.
- R7: The power-down flag clears on `evt_sleep`. This event takes priority over `evt_clrwdt`. Without it, `evt_clrwdt` sets the flag. `evt_wdt_to` does not change this flag.
- R8: With no write, no update and no event, every bit holds its value.
- R9: A clear instruction writes 0 with only the Z update enabled and Z=1. It leaves the upper three bits 0 and Z set, with DC, C, time-out and power-down unchanged.
- R10: A synchronous `rst` loads `stat_o` with 8'h18: time-out and power-down set, Z, DC and C cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sw_we | input | 1 | The instruction writes this register |
| sw_wdata | input | 8 | Data written by the instruction |
| alu_upd | input | 3 | Per-flag ALU update enables {Z, DC, C} |
| alu_flags | input | 3 | ALU flag results {Z, DC, C} |
| evt_clrwdt | input | 1 | A watchdog-clear instruction executed |
| evt_sleep | input | 1 | Sleep entered |
| evt_wdt_to | input | 1 | Watchdog time-out occurred |
| stat_o | output | 8 | Register read value |

## Verification
The bench builds the block with its default 8-bit data width and three arithmetic flags, the only variant the field layout allows. The small width brings every combination within reach. The bench runs all eight patterns of `alu_upd` against a software write, all eight event combinations, including simultaneous time-out, sleep and clear, and the clear-instruction case. A long random run then compares every clock against the bench's reference model.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned ARITH_N = 3;
  localparam int unsigned BIT_C   = 0;
  localparam int unsigned BIT_DC  = 1;
  localparam int unsigned BIT_Z   = 2;
  localparam int unsigned BIT_PD  = 3;
  localparam int unsigned BIT_TO  = 4;
  localparam int unsigned USED_W  = BIT_TO + 1;

  typedef struct packed {
    logic to_f;
    logic pd_f;
  } pwr_flags_t;

  localparam pwr_flags_t PWR_RESET = '{to_f: 1'b1, pd_f: 1'b1};
endpackage

// File: rtl/status_flag_arb.sv
module status_flag_arb #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] upd_i,
  input  logic [N-1:0] alu_i,
  input  logic         sw_we_i,
  input  logic [N-1:0] sw_i,
  output logic [N-1:0] nxt_o
);
  logic any_upd;
  assign any_upd = |upd_i;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_comb begin
      if (upd_i[g])                nxt_o[g] = alu_i[g];
      else if (sw_we_i && !any_upd) nxt_o[g] = sw_i[g];
      else                         nxt_o[g] = cur_i[g];
    end
  end
endmodule

// File: rtl/status_pwr_track.sv
module status_pwr_track
  import cpu_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clrwdt_i,
  input  logic       sleep_i,
  input  logic       wdt_to_i,
  output pwr_flags_t pwr_o
);
  pwr_flags_t pwr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q <= PWR_RESET;
    end else begin
      if (wdt_to_i)                 pwr_q.to_f <= 1'b0;
      else if (clrwdt_i || sleep_i) pwr_q.to_f <= 1'b1;
      if (sleep_i)                  pwr_q.pd_f <= 1'b0;
      else if (clrwdt_i)            pwr_q.pd_f <= 1'b1;
    end
  end

  assign pwr_o = pwr_q;
endmodule

// File: rtl/status_pack.sv
module status_pack
  import cpu_status_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic [ARITH_N-1:0] arith_i,
  input  pwr_flags_t         pwr_i,
  output logic [W-1:0]       stat_o
);
  localparam int unsigned PAD_W = W - USED_W;

  always_comb begin
    stat_o                     = '0;
    stat_o[ARITH_N-1:0]        = arith_i;
    stat_o[BIT_PD]             = pwr_i.pd_f;
    stat_o[BIT_TO]             = pwr_i.to_f;
    stat_o[W-1 -: PAD_W]       = '0;
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import cpu_status_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_we,
  input  logic [W-1:0]       sw_wdata,
  input  logic [ARITH_N-1:0] alu_upd,
  input  logic [ARITH_N-1:0] alu_flags,
  input  logic               evt_clrwdt,
  input  logic               evt_sleep,
  input  logic               evt_wdt_to,
  output logic [W-1:0]       stat_o
);
  logic [ARITH_N-1:0] arith_q;
  logic [ARITH_N-1:0] arith_nxt;
  pwr_flags_t         pwr;

  status_flag_arb #(.N(ARITH_N)) u_arb (
    .cur_i   (arith_q),
    .upd_i   (alu_upd),
    .alu_i   (alu_flags),
    .sw_we_i (sw_we),
    .sw_i    (sw_wdata[ARITH_N-1:0]),
    .nxt_o   (arith_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) arith_q <= '0;
    else     arith_q <= arith_nxt;
  end

  status_pwr_track u_pwr (
    .clk      (clk),
    .rst      (rst),
    .clrwdt_i (evt_clrwdt),
    .sleep_i  (evt_sleep),
    .wdt_to_i (evt_wdt_to),
    .pwr_o    (pwr)
  );

  status_pack #(.W(W)) u_pack (
    .arith_i (arith_q),
    .pwr_i   (pwr),
    .stat_o  (stat_o)
  );
endmodule

// File: rtl/cpu_status_reg_chk.sv
module cpu_status_reg_chk
  import cpu_status_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input logic               clk,
  input logic               rst,
  input logic               sw_we,
  input logic [W-1:0]       sw_wdata,
  input logic [ARITH_N-1:0] alu_upd,
  input logic [ARITH_N-1:0] alu_flags,
  input logic               evt_clrwdt,
  input logic               evt_sleep,
  input logic               evt_wdt_to,
  input logic [W-1:0]       stat_o
);
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    stat_o[W-1:USED_W] == '0);

  p_sw_load_r3: assert property (@(posedge clk) disable iff (rst)
    (sw_we && alu_upd == '0) |=> stat_o[ARITH_N-1:0] == $past(sw_wdata[ARITH_N-1:0]));

  p_alu_wins_c_r4: assert property (@(posedge clk) disable iff (rst)
    alu_upd[BIT_C] |=> stat_o[BIT_C] == $past(alu_flags[BIT_C]));

  p_alu_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (alu_upd != '0 && !alu_upd[BIT_DC]) |=> $stable(stat_o[BIT_DC]));

  p_pwr_readonly_r5: assert property (@(posedge clk) disable iff (rst)
    !(evt_clrwdt || evt_sleep || evt_wdt_to) |=> $stable(stat_o[BIT_TO:BIT_PD]));

  p_to_clear_r6: assert property (@(posedge clk) disable iff (rst)
    evt_wdt_to |=> !stat_o[BIT_TO]);

  p_pd_clear_r7: assert property (@(posedge clk) disable iff (rst)
    evt_sleep |=> !stat_o[BIT_PD]);

  p_reset_r10: assert property (@(posedge clk)
    rst |=> stat_o == W'(8'h18));
endmodule

bind cpu_status_reg cpu_status_reg_chk #(.W(W)) u_chk (.*);

// File: tb/sim_cpu_status_reg.sv
`timescale 1ns/1ps
module sim_cpu_status_reg;
  logic       clk = 1'b0;
  logic       rst;
  logic       sw_we;
  logic [7:0] sw_wdata;
  logic [2:0] alu_upd;
  logic [2:0] alu_flags;
  logic       evt_clrwdt, evt_sleep, evt_wdt_to;
  logic [7:0] stat_o;

  int checks = 0;
  int errors = 0;
  bit m_to, m_pd, m_z, m_dc, m_c;

  always #2.5 clk = ~clk;

  cpu_status_reg u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_val();
    return {3'b000, m_to, m_pd, m_z, m_dc, m_c};
  endfunction

  task automatic step(input bit r, input bit we, input logic [7:0] d,
                      input logic [2:0] up, input logic [2:0] af,
                      input bit cw, input bit sl, input bit to);
    bit any;
    rst = r; sw_we = we; sw_wdata = d; alu_upd = up; alu_flags = af;
    evt_clrwdt = cw; evt_sleep = sl; evt_wdt_to = to;
    @(posedge clk);
    if (r) begin
      m_to = 1; m_pd = 1; m_z = 0; m_dc = 0; m_c = 0;
    end else begin
      any = (up != 3'b000);
      if (up[2]) m_z = af[2]; else if (we && !any) m_z = d[2];
      if (up[1]) m_dc = af[1]; else if (we && !any) m_dc = d[1];
      if (up[0]) m_c = af[0]; else if (we && !any) m_c = d[0];
      if (to) m_to = 0; else if (cw || sl) m_to = 1;
      if (sl) m_pd = 0; else if (cw) m_pd = 1;
    end
    @(negedge clk);
    chk("R1 upper bits", {5'b0, stat_o[7:5]}, 8'h00);
    chk("R6/R7 power bits", {6'b0, stat_o[4:3]}, {6'b0, m_to, m_pd});
    chk("R3/R4 arith bits", {5'b0, stat_o[2:0]}, {5'b0, m_z, m_dc, m_c});
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1, 0, 8'h00, 3'b000, 3'b000, 0, 0, 0);
    step(1, 0, 8'h00, 3'b000, 3'b000, 0, 0, 0);
    chk("R10 reset value", stat_o, 8'h18);
    // R3 / R5: plain write, upper and power bits from data ignored
    step(0, 1, 8'hE7, 3'b000, 3'b000, 0, 0, 0);
    chk("R3 R5 write FF-ish", stat_o, 8'h1F);
    step(0, 1, 8'h02, 3'b000, 3'b000, 0, 0, 0);
    chk("R2 DC at bit1", stat_o, 8'h1A);
    // R8 hold
    step(0, 0, 8'hFF, 3'b000, 3'b111, 0, 0, 0);
    chk("R8 hold", stat_o, 8'h1A);
    // R4: every update pattern against a write
    for (int u = 1; u < 8; u++) begin
      step(0, 1, 8'h05, 3'b000, 3'b000, 0, 0, 0);
      step(0, 1, 8'h02, 3'(u), 3'b010, 0, 0, 0);
      chk("R4 alu wins", stat_o,
          {3'b0, 2'b11, u[2] ? 1'b0 : 1'b1, u[1] ? 1'b1 : 1'b0, u[0] ? 1'b0 : 1'b1});
    end
    // R9 clear instruction
    step(0, 1, 8'h03, 3'b000, 3'b000, 0, 0, 0);
    step(0, 1, 8'h00, 3'b100, 3'b100, 0, 0, 0);
    chk("R9 clear", stat_o, 8'h1F);
    // R6/R7 events
    step(0, 0, 8'h00, 3'b000, 3'b000, 0, 1, 0);
    chk("R7 sleep clears PD", stat_o, 8'h17);
    step(0, 0, 8'h00, 3'b000, 3'b000, 0, 0, 1);
    chk("R6 timeout clears TO", stat_o, 8'h07);
    step(0, 1, 8'hFF, 3'b000, 3'b000, 0, 0, 0);
    chk("R5 power bits read-only", stat_o, 8'h07);
    step(0, 0, 8'h00, 3'b000, 3'b000, 1, 0, 0);
    chk("R6 R7 clrwdt sets", stat_o, 8'h1F);
    step(0, 0, 8'h00, 3'b000, 3'b000, 1, 1, 1);
    chk("R6 R7 priority all events", stat_o, 8'h07);
    step(0, 0, 8'h00, 3'b000, 3'b000, 1, 1, 0);
    chk("R7 sleep beats clrwdt", stat_o, 8'h17);
    for (int e = 0; e < 8; e++)
      step(0, 0, 8'h00, 3'b000, 3'b000, e[0], e[1], e[2]);
    for (int i = 0; i < 2000; i++)
      step(($urandom % 97) == 0, $urandom % 2, 8'($urandom), 3'($urandom),
           3'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 6) == 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule